// File: doc/BRIEF.md
# Slot-Banked Multithreaded Register File

This block holds the integer registers of a core whose pipeline interleaves threads over C repeating time slots. Each time slot owns a separate register file, and every file is divided into banks, one per hardware thread mapped to that slot. A thread with ID `t` lives in file `t mod C`, bank `t div C`. Only one file is active in any cycle, so all banks of a file can share one pair of read ports and one write port without conflict.

Reads are combinational. The one-hot slot enable picks the active file, `rd_bank` picks the bank within it, and two register numbers select the operands. The selected words are driven onto a single shared output bus. Writeback takes a slot ID, a full thread ID and a destination register, and commits on the clock edge whether or not that slot is enabled. Register 0 always reads as zero. A read of the word being written in the same cycle returns the new data.

Top module: `slot_regfile`

## Requirements
- R1: A word written with writeback slot `s` and thread `t` (bank = `t div SLOTS`) is returned on a later cycle when `slot_en` has only bit `s` set and `rd_bank` equals that bank.
- R2: A write changes only the addressed register in the addressed bank of the addressed file. The same register number in the other bank of that file, and in every other file, keeps its value.
- R3: Register 0 always reads as zero on both ports, and writes to register 0 are discarded.
- R4: When a read port addresses the word being written in the same cycle (same file as the active enable, same bank, same nonzero register), it returns `wb_data` in that cycle.
- R5: The two read ports are independent: `rs_a` and `rs_b` may address different registers of the selected bank in the same cycle, and each returns its own word.
- R6: When `slot_en` is all zeros, both read outputs are zero.
- R7: After reset, every register of every bank and file reads as zero.
- R8: A write commits whether or not its destination slot is currently enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset that clears all registers |
| slot_en | input | SLOTS | One-hot enable of the file that is read in this cycle |
| rd_bank | input | BW | Bank (thread div SLOTS) read within the enabled file |
| rs_a | input | RW | Register number for read port A |
| rs_b | input | RW | Register number for read port B |
| rdata_a | output | DW | Read port A data |
| rdata_b | output | DW | Read port B data |
| we | input | 1 | Writeback valid |
| wb_slot | input | SW | File written by writeback |
| wb_thread | input | TW | Thread ID; its quotient by SLOTS selects the bank |
| wb_reg | input | RW | Destination register |
| wb_data | input | DW | Writeback data |

## Verification
Writeback and operand read can target the same word in one cycle. The bench provokes this for every thread by writing a fresh value to a register while port A reads that register, and port B reads a neighbour that must still show its old value. Port A must return the new value before the edge. In a second pass the write goes to the other bank of the same file, where port A must keep the stored value and show no forwarding.

// File: rtl/slot_regfile.sv
module slot_regfile #(
  parameter int SLOTS   = 4,
  parameter int THREADS = 8,
  parameter int DW      = 32,
  parameter int NREG    = 32,
  localparam int BANKS  = THREADS / SLOTS,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BW     = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] slot_en,
  input  logic [BW-1:0]    rd_bank,
  input  logic [RW-1:0]    rs_a,
  input  logic [RW-1:0]    rs_b,
  output logic [DW-1:0]    rdata_a,
  output logic [DW-1:0]    rdata_b,
  input  logic             we,
  input  logic [SW-1:0]    wb_slot,
  input  logic [TW-1:0]    wb_thread,
  input  logic [RW-1:0]    wb_reg,
  input  logic [DW-1:0]    wb_data
);

  logic [DW-1:0] mem [SLOTS][BANKS][NREG];
  logic [TW-1:0] wb_quot;
  logic [BW-1:0] wb_bank;
  logic [SW-1:0] act_slot;
  logic [DW-1:0] bus_a, bus_b;
  logic          hit_a, hit_b;

  assign wb_quot = wb_thread / TW'(SLOTS);
  assign wb_bank = wb_quot[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int b = 0; b < BANKS; b++)
          for (int r = 0; r < NREG; r++)
            mem[s][b][r] <= '0;
    end else if (we && wb_reg != '0) begin
      mem[wb_slot][wb_bank][wb_reg] <= wb_data;
    end
  end

  always_comb begin
    bus_a    = '0;
    bus_b    = '0;
    act_slot = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_en[s]) begin
        bus_a    = bus_a | mem[s][rd_bank][rs_a];
        bus_b    = bus_b | mem[s][rd_bank][rs_b];
        act_slot = act_slot | SW'(s);
      end
    end
  end

  wire wb_here = we && (|slot_en) && wb_slot == act_slot && wb_bank == rd_bank;
  assign hit_a = wb_here && wb_reg == rs_a && rs_a != '0;
  assign hit_b = wb_here && wb_reg == rs_b && rs_b != '0;

  assign rdata_a = (rs_a == '0) ? '0 : hit_a ? wb_data : bus_a;
  assign rdata_b = (rs_b == '0) ? '0 : hit_b ? wb_data : bus_b;

  a_r1_enable_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_en));

  a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_a == '0) |-> (rdata_a == '0 && (rs_b != '0 || rdata_b == '0)));

  a_r6_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en == '0) |-> (rdata_a == '0 && rdata_b == '0));

  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wb_reg != '0 && wb_reg == rs_a && slot_en == (SLOTS'(1) << wb_slot)
     && rd_bank == wb_bank) |-> (rdata_a == wb_data));

  a_r1_write_persists: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wb_reg) != '0 && !we
     && rs_a == $past(wb_reg) && rd_bank == $past(wb_bank)
     && slot_en == (SLOTS'(1) << $past(wb_slot))) |-> (rdata_a == $past(wb_data)));

endmodule

// File: tb/slot_regfile_tb.sv
module slot_regfile_tb;
  localparam int C = 4, T = 8, DW = 32, NR = 32;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [C-1:0] slot_en;
  logic [0:0] rd_bank;
  logic [4:0] rs_a, rs_b, wb_reg;
  logic [DW-1:0] rdata_a, rdata_b, wb_data;
  logic we;
  logic [1:0] wb_slot;
  logic [2:0] wb_thread;

  slot_regfile #(.SLOTS(C), .THREADS(T), .DW(DW), .NREG(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .rd_bank(rd_bank),
    .rs_a(rs_a), .rs_b(rs_b), .rdata_a(rdata_a), .rdata_b(rdata_b),
    .we(we), .wb_slot(wb_slot), .wb_thread(wb_thread), .wb_reg(wb_reg),
    .wb_data(wb_data));

  int checks = 0, fails = 0;
  logic [DW-1:0] model [T][NR];

  function automatic logic [DW-1:0] pat(int t, int r, int k);
    return DW'(t * 32'h0101_0000 + r * 32'h0000_0103 + k * 32'h2000_0001 + 1);
  endfunction

  function automatic logic [DW-1:0] want(int t, int r);
    return (r == 0) ? '0 : model[t][r];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(int t_rd, int ra, int rb, bit en, bit w, int t_wr, int wr, logic [DW-1:0] wd);
    @(negedge clk);
    slot_en   = en ? C'(1) << (t_rd % C) : '0;
    rd_bank   = 1'(t_rd / C);
    rs_a      = 5'(ra);
    rs_b      = 5'(rb);
    we        = w;
    wb_slot   = 2'(t_wr % C);
    wb_thread = 3'(t_wr);
    wb_reg    = 5'(wr);
    wb_data   = wd;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; slot_en = '0; rd_bank = '0; rs_a = '0; rs_b = '0;
    we = 0; wb_slot = '0; wb_thread = '0; wb_reg = '0; wb_data = '0;
    for (int t = 0; t < T; t++) for (int r = 0; r < NR; r++) model[t][r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7: everything zero after reset
    for (int t = 0; t < T; t++)
      for (int r = 0; r < NR; r++) begin
        drive(t, r, NR - 1 - r, 1, 0, 0, 0, '0);
        check("R7 port a", rdata_a, '0);
        check("R7 port b", rdata_b, '0);
      end

    // R8/R6: write everything while no slot is enabled; R3 via reg 0 writes
    for (int t = 0; t < T; t++)
      for (int r = 0; r < NR; r++) begin
        drive(t, r, 0, 0, 1, t, r, pat(t, r, 0));
        check("R6 idle a", rdata_a, '0);
        check("R6 idle b", rdata_b, '0);
        if (r != 0) model[t][r] = pat(t, r, 0);
      end

    // R1/R2/R3/R5: full read-back, two ports on different registers
    for (int t = 0; t < T; t++)
      for (int r = 0; r < NR; r++) begin
        drive(t, r, (r * 7 + 3) % NR, 1, 0, 0, 0, '0);
        check("R1 R3 port a", rdata_a, want(t, r));
        check("R5 port b", rdata_b, want(t, (r * 7 + 3) % NR));
      end

    // R4: same-cycle read/write of one word; port b sees neighbour unchanged
    for (int t = 0; t < T; t++)
      for (int r = 1; r < NR; r += 5) begin
        drive(t, r, (r % (NR - 1)) + 1, 1, 1, t, r, pat(t, r, 1));
        check("R4 bypass a", rdata_a, pat(t, r, 1));
        check("R4 neighbour b", rdata_b, want(t, (r % (NR - 1)) + 1));
        model[t][r] = pat(t, r, 1);
        drive(t, r, 0, 1, 0, 0, 0, '0);
        check("R1 after bypass", rdata_a, want(t, r));
        check("R3 port b", rdata_b, '0);
      end

    // R2: write other bank of same file while reading; no forwarding, no leak
    for (int t = 0; t < T; t++) begin
      drive(t, 9, 9, 1, 1, (t + C) % T, 9, pat(t, 9, 2));
      check("R2 no cross-bank bypass", rdata_a, want(t, 9));
      model[(t + C) % T][9] = pat(t, 9, 2);
      drive(t, 9, 0, 1, 0, 0, 0, '0);
      check("R2 bank isolated", rdata_a, want(t, 9));
      drive((t + C) % T, 9, 0, 1, 0, 0, 0, '0);
      check("R2 target written", rdata_a, want((t + C) % T, 9));
    end

    // R3: write to reg 0 with read of reg 0 same cycle
    drive(5, 0, 0, 1, 1, 5, 0, 32'hFFFF_FFFF);
    check("R3 reg0 during write", rdata_a, '0);
    drive(5, 0, 0, 1, 0, 0, 0, '0);
    check("R3 reg0 after write", rdata_b, '0);

    // R6 final idle
    drive(2, 4, 7, 0, 0, 0, 0, '0);
    check("R6 idle final a", rdata_a, '0);
    check("R6 idle final b", rdata_b, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule